// File: doc/BRIEF.md
# I/O Access Trap Controller

This block sits in the host I/O path in front of a set of peripherals that power management may switch off. Each trap slot has an arm bit and a base/mask address window. When a host cycle in I/O space falls inside the window of an armed slot, the block blocks the cycle so it does not reach the device. A trapped read returns all-ones to the host, and a trapped write is dropped.

The block also records the trap so that management software can replay the access. It sets a sticky per-slot status bit. If no earlier trap is pending, it latches the slot index, the address, the direction and the write data. A management interrupt stays high while any status bit is set. The handler powers the device up, clears the arm bit and the status bit, and then restarts the I/O access from the latched record.

Top module: `io_trap_ctrl`

## Requirements
- R1: Slot k hits when `hst_valid`, `hst_io` and `trap_arm[k]` are all 1 and `((hst_addr ^ base_k) & ~mask_k) == 0`. Slot k's base and mask sit at bits [k*ADDR_W +: ADDR_W] of `trap_base` and `trap_mask`, and a mask bit of 1 makes that address bit don't-care. `hst_trapped` is 1 in the same cycle if any slot hits.
- R2: A cycle with `hst_io` = 0 never traps, whatever the slot settings are, and it is forwarded.
- R3: `dev_valid` equals `hst_valid` when no slot hits and is 0 when a slot hits. `dev_addr`, `dev_write` and `dev_wdata` always equal the host values.
- R4: On a trapped read (`hst_write` = 0), `hst_rdata` is all-ones. Otherwise `hst_rdata` equals `dev_rdata`.
- R5: At the clock edge that samples a trap, the status bit `trap_sts[k]` of the recorded slot is set. No other status bit changes because of that trap.
- R6: When several slots hit at once, the lowest-indexed slot is the one recorded in both `trap_sts` and `cap_idx`.
- R7: When `trap_sts` is all zero before the edge, a trap latches `cap_idx`, `cap_addr`, `cap_write` (1 = write) and `cap_wdata`. While any status bit is set, these capture fields hold their values.
- R8: When `clr_valid` is 1, every status bit with a 1 in `clr_bits` is cleared at the edge. A set from a trap in the same cycle wins over the clear.
- R9: `smi` is 1 exactly when at least one status bit is set.
- R10: After reset, `trap_sts`, `smi` and all capture fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_valid | input | 1 | Host cycle present |
| hst_io | input | 1 | 1 = I/O-space cycle |
| hst_write | input | 1 | 1 = write, 0 = read |
| hst_addr | input | ADDR_W | Host cycle address |
| hst_wdata | input | DATA_W | Host write data |
| hst_rdata | output | DATA_W | Read data returned to host |
| hst_trapped | output | 1 | Current cycle is trapped |
| dev_valid | output | 1 | Cycle forwarded to device |
| dev_write | output | 1 | Forwarded direction |
| dev_addr | output | ADDR_W | Forwarded address |
| dev_wdata | output | DATA_W | Forwarded write data |
| dev_rdata | input | DATA_W | Device read data |
| trap_arm | input | NUM_TRAPS | Per-slot arm bits |
| trap_base | input | NUM_TRAPS*ADDR_W | Packed per-slot base addresses |
| trap_mask | input | NUM_TRAPS*ADDR_W | Packed per-slot don't-care masks |
| clr_valid | input | 1 | Status clear strobe |
| clr_bits | input | NUM_TRAPS | Write-1-to-clear status mask |
| trap_sts | output | NUM_TRAPS | Sticky per-slot trap status |
| cap_idx | output | IDX_W | Recorded slot index |
| cap_addr | output | ADDR_W | Recorded address |
| cap_write | output | 1 | Recorded direction |
| cap_wdata | output | DATA_W | Recorded write data |
| smi | output | 1 | Management interrupt |

## Verification
The bench uses four slots and an 8-bit address. Slot 0 is a single address and slot 1 is a 16-address window that contains it, so at that address two slots overlap. Slot 2 is a 64-address window and slot 3 is an 8-address window. The bench sweeps every address with both directions and both address spaces, under three arm patterns. This separates armed from disarmed slots, I/O cycles from other cycles, and the lowest-index choice from any other choice. Directed sequences then trap while an earlier trap is still pending to show that the capture holds. They also clear the status bits one at a time, and apply a clear in the same cycle as a new trap on the same slot.

// File: rtl/io_trap_pkg.sv
package io_trap_pkg;

  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } io_dir_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/io_trap_decode.sv
module io_trap_decode #(
  parameter int unsigned NUM_TRAPS = 4,
  parameter int unsigned ADDR_W    = 16
) (
  input  logic                          cyc_valid,
  input  logic                          cyc_io,
  input  logic [ADDR_W-1:0]             cyc_addr,
  input  logic [NUM_TRAPS-1:0]          arm,
  input  logic [NUM_TRAPS*ADDR_W-1:0]   base_flat,
  input  logic [NUM_TRAPS*ADDR_W-1:0]   mask_flat,
  output logic [NUM_TRAPS-1:0]          hit
);

  logic io_cyc;

  assign io_cyc = cyc_valid & cyc_io;

  for (genvar k = 0; k < NUM_TRAPS; k++) begin : g_slot
    logic [ADDR_W-1:0] base_k;
    logic [ADDR_W-1:0] care_k;
    logic              in_win;

    assign base_k = base_flat[k*ADDR_W +: ADDR_W];
    assign care_k = ~mask_flat[k*ADDR_W +: ADDR_W];
    assign in_win = ((cyc_addr ^ base_k) & care_k) == '0;
    assign hit[k] = io_cyc & arm[k] & in_win;
  end

endmodule

// File: rtl/io_trap_prio.sv
module io_trap_prio #(
  parameter int unsigned NUM_TRAPS = 4,
  localparam int unsigned IDX_W    = io_trap_pkg::idx_width(NUM_TRAPS)
) (
  input  logic [NUM_TRAPS-1:0] req,
  output logic                 any,
  output logic [IDX_W-1:0]     win_idx,
  output logic [NUM_TRAPS-1:0] win_oh
);

  always_comb begin
    win_idx = '0;
    win_oh  = '0;
    for (int i = NUM_TRAPS - 1; i >= 0; i--) begin
      if (req[i]) begin
        win_idx = IDX_W'(i);
        win_oh  = '0;
        win_oh[i] = 1'b1;
      end
    end
  end

  assign any = |req;

endmodule

// File: rtl/io_trap_status.sv
module io_trap_status #(
  parameter int unsigned NUM_TRAPS = 4,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  localparam int unsigned IDX_W    = io_trap_pkg::idx_width(NUM_TRAPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  logic [NUM_TRAPS-1:0] fire_oh,
  input  logic [IDX_W-1:0]     fire_idx,
  input  logic [ADDR_W-1:0]    fire_addr,
  input  logic                 fire_write,
  input  logic [DATA_W-1:0]    fire_wdata,
  input  logic                 clr_valid,
  input  logic [NUM_TRAPS-1:0] clr_bits,
  output logic [NUM_TRAPS-1:0] sts,
  output logic [IDX_W-1:0]     cap_idx,
  output logic [ADDR_W-1:0]    cap_addr,
  output logic                 cap_write,
  output logic [DATA_W-1:0]    cap_wdata,
  output logic                 irq
);
  import io_trap_pkg::*;

  logic [NUM_TRAPS-1:0] sts_q, sts_d;
  logic                 sts_en;
  logic                 cap_en;
  logic [IDX_W-1:0]     idx_q;
  logic [ADDR_W-1:0]    addr_q;
  io_dir_e              dir_q, dir_d;
  logic [DATA_W-1:0]    wdata_q;
  logic                 irq_q, irq_d;

  always_comb begin
    sts_d = sts_q;
    if (clr_valid) sts_d = sts_d & ~clr_bits;
    if (fire)      sts_d = sts_d | fire_oh;
    sts_en = fire | clr_valid;
    cap_en = fire & (sts_q == '0);
    dir_d  = fire_write ? DIR_WR : DIR_RD;
    irq_d  = |sts_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      irq_q <= 1'b0;
    end else if (sts_en) begin
      sts_q <= sts_d;
      irq_q <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      addr_q  <= '0;
      dir_q   <= DIR_RD;
      wdata_q <= '0;
    end else if (cap_en) begin
      idx_q   <= fire_idx;
      addr_q  <= fire_addr;
      dir_q   <= dir_d;
      wdata_q <= fire_wdata;
    end
  end

  assign sts       = sts_q;
  assign irq       = irq_q;
  assign cap_idx   = idx_q;
  assign cap_addr  = addr_q;
  assign cap_write = (dir_q == DIR_WR);
  assign cap_wdata = wdata_q;

endmodule

// File: rtl/io_trap_ctrl.sv
module io_trap_ctrl #(
  parameter int unsigned NUM_TRAPS = 4,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  localparam int unsigned IDX_W    = io_trap_pkg::idx_width(NUM_TRAPS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          hst_valid,
  input  logic                          hst_io,
  input  logic                          hst_write,
  input  logic [ADDR_W-1:0]             hst_addr,
  input  logic [DATA_W-1:0]             hst_wdata,
  output logic [DATA_W-1:0]             hst_rdata,
  output logic                          hst_trapped,
  output logic                          dev_valid,
  output logic                          dev_write,
  output logic [ADDR_W-1:0]             dev_addr,
  output logic [DATA_W-1:0]             dev_wdata,
  input  logic [DATA_W-1:0]             dev_rdata,
  input  logic [NUM_TRAPS-1:0]          trap_arm,
  input  logic [NUM_TRAPS*ADDR_W-1:0]   trap_base,
  input  logic [NUM_TRAPS*ADDR_W-1:0]   trap_mask,
  input  logic                          clr_valid,
  input  logic [NUM_TRAPS-1:0]          clr_bits,
  output logic [NUM_TRAPS-1:0]          trap_sts,
  output logic [IDX_W-1:0]              cap_idx,
  output logic [ADDR_W-1:0]             cap_addr,
  output logic                          cap_write,
  output logic [DATA_W-1:0]             cap_wdata,
  output logic                          smi
);

  logic [NUM_TRAPS-1:0] hit;
  logic                 any_hit;
  logic [IDX_W-1:0]     win_idx;
  logic [NUM_TRAPS-1:0] win_oh;

  io_trap_decode #(
    .NUM_TRAPS (NUM_TRAPS),
    .ADDR_W    (ADDR_W)
  ) u_decode (
    .cyc_valid (hst_valid),
    .cyc_io    (hst_io),
    .cyc_addr  (hst_addr),
    .arm       (trap_arm),
    .base_flat (trap_base),
    .mask_flat (trap_mask),
    .hit       (hit)
  );

  io_trap_prio #(
    .NUM_TRAPS (NUM_TRAPS)
  ) u_prio (
    .req     (hit),
    .any     (any_hit),
    .win_idx (win_idx),
    .win_oh  (win_oh)
  );

  io_trap_status #(
    .NUM_TRAPS (NUM_TRAPS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
  ) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (any_hit),
    .fire_oh    (win_oh),
    .fire_idx   (win_idx),
    .fire_addr  (hst_addr),
    .fire_write (hst_write),
    .fire_wdata (hst_wdata),
    .clr_valid  (clr_valid),
    .clr_bits   (clr_bits),
    .sts        (trap_sts),
    .cap_idx    (cap_idx),
    .cap_addr   (cap_addr),
    .cap_write  (cap_write),
    .cap_wdata  (cap_wdata),
    .irq        (smi)
  );

  // Forwarding gate: a trapped cycle never reaches the device.
  assign hst_trapped = any_hit;
  assign dev_valid   = hst_valid & ~any_hit;
  assign dev_write   = hst_write;
  assign dev_addr    = hst_addr;
  assign dev_wdata   = hst_wdata;
  assign hst_rdata   = (any_hit && !hst_write) ? {DATA_W{1'b1}} : dev_rdata;

endmodule

// File: rtl/io_trap_ctrl_chk.sv
module io_trap_ctrl_chk #(
  parameter int unsigned NUM_TRAPS = 4,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  localparam int unsigned IDX_W    = io_trap_pkg::idx_width(NUM_TRAPS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 hst_valid,
  input logic                 hst_io,
  input logic                 hst_write,
  input logic [DATA_W-1:0]    hst_rdata,
  input logic                 hst_trapped,
  input logic                 dev_valid,
  input logic                 clr_valid,
  input logic [NUM_TRAPS-1:0] clr_bits,
  input logic [NUM_TRAPS-1:0] trap_sts,
  input logic [IDX_W-1:0]     cap_idx,
  input logic [ADDR_W-1:0]    cap_addr,
  input logic                 smi
);

  a_r2_mem_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_valid && !hst_io) |-> (dev_valid && !hst_trapped));

  a_r3_no_leak: assert property (@(posedge clk) disable iff (!rst_n)
    hst_trapped |-> !dev_valid);

  a_r4_read_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_trapped && !hst_write) |-> (hst_rdata == {DATA_W{1'b1}}));

  a_r5_single_set: assert property (@(posedge clk) disable iff (!rst_n)
    hst_trapped |=> ((trap_sts != '0) &&
                     ($countones(trap_sts & ~$past(trap_sts)) <= 1)));

  a_r7_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_sts != '0) |=> ($stable(cap_addr) && $stable(cap_idx)));

  a_r8_full_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid && (clr_bits == trap_sts) && !hst_trapped) |=> (trap_sts == '0));

  a_r9_smi_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smi) |-> $past(hst_trapped));

  a_r9_smi_level: assert property (@(posedge clk) disable iff (!rst_n)
    smi |-> (trap_sts != '0));

endmodule

bind io_trap_ctrl io_trap_ctrl_chk #(
  .NUM_TRAPS (NUM_TRAPS),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hst_valid   (hst_valid),
  .hst_io      (hst_io),
  .hst_write   (hst_write),
  .hst_rdata   (hst_rdata),
  .hst_trapped (hst_trapped),
  .dev_valid   (dev_valid),
  .clr_valid   (clr_valid),
  .clr_bits    (clr_bits),
  .trap_sts    (trap_sts),
  .cap_idx     (cap_idx),
  .cap_addr    (cap_addr),
  .smi         (smi)
);

// File: tb/io_trap_ctrl_test.sv
module io_trap_ctrl_test;

  localparam int NT = 4;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          hst_valid, hst_io, hst_write;
  logic [AW-1:0] hst_addr;
  logic [DW-1:0] hst_wdata, hst_rdata, dev_rdata, dev_wdata, cap_wdata;
  logic          hst_trapped, dev_valid, dev_write, cap_write, smi;
  logic [AW-1:0] dev_addr, cap_addr;
  logic [NT-1:0] trap_arm, clr_bits, trap_sts;
  logic [NT*AW-1:0] trap_base, trap_mask;
  logic          clr_valid;
  logic [IW-1:0] cap_idx;

  int checks = 0;
  int errors = 0;

  logic [AW-1:0] base_a [NT];
  logic [AW-1:0] mask_a [NT];

  always #10 clk = ~clk;

  io_trap_ctrl #(.NUM_TRAPS(NT), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .hst_valid(hst_valid), .hst_io(hst_io), .hst_write(hst_write),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .hst_trapped(hst_trapped),
    .dev_valid(dev_valid), .dev_write(dev_write), .dev_addr(dev_addr),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata),
    .trap_arm(trap_arm), .trap_base(trap_base), .trap_mask(trap_mask),
    .clr_valid(clr_valid), .clr_bits(clr_bits),
    .trap_sts(trap_sts), .cap_idx(cap_idx), .cap_addr(cap_addr),
    .cap_write(cap_write), .cap_wdata(cap_wdata), .smi(smi)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Reference: lowest armed slot whose window contains a (R1, R2, R6).
  function automatic int exp_win(input logic [AW-1:0] a, input logic io);
    if (!io) return -1;
    for (int k = 0; k < NT; k++)
      if (trap_arm[k] && (((a ^ base_a[k]) & ~mask_a[k]) == '0)) return k;
    return -1;
  endfunction

  task automatic load_cfg(input logic [NT-1:0] arm);
    @(negedge clk);
    trap_arm = arm;
    for (int k = 0; k < NT; k++) begin
      trap_base[k*AW +: AW] = base_a[k];
      trap_mask[k*AW +: AW] = mask_a[k];
    end
  endtask

  task automatic sweep_one(input logic [AW-1:0] a, input logic io, input logic wr);
    int w;
    logic [DW-1:0] wd, rd;
    wd = a ^ 8'h5A;
    rd = a + 8'd3;
    @(negedge clk);
    hst_valid = 1'b1; hst_io = io; hst_write = wr;
    hst_addr = a; hst_wdata = wd; dev_rdata = rd;
    #1;
    w = exp_win(a, io);
    chk(hst_trapped == (w >= 0), "R1 hit", 32'(hst_trapped), 32'(w >= 0));
    if (!io) chk(dev_valid == 1'b1, "R2 forward", 32'(dev_valid), 1);
    chk(dev_valid == (w < 0), "R3 gate", 32'(dev_valid), 32'(w < 0));
    chk(dev_addr == a && dev_wdata == wd && dev_write == wr, "R3 pass",
        {dev_addr, dev_wdata}, {a, wd});
    if (!wr)
      chk(hst_rdata == ((w >= 0) ? 8'hFF : rd), "R4 rdata",
          32'(hst_rdata), 32'((w >= 0) ? 8'hFF : rd));
    @(posedge clk); #1;
    hst_valid = 1'b0;
    chk(trap_sts == ((w >= 0) ? NT'(1 << w) : '0), "R5 R6 status",
        32'(trap_sts), 32'((w >= 0) ? (1 << w) : 0));
    chk(smi == (w >= 0), "R9 smi", 32'(smi), 32'(w >= 0));
    if (w >= 0) begin
      chk(cap_idx == IW'(w), "R6 cap_idx", 32'(cap_idx), 32'(w));
      chk(cap_addr == a && cap_write == wr && cap_wdata == wd, "R7 capture",
          {cap_write, cap_addr, cap_wdata}, {wr, a, wd});
      @(negedge clk);
      clr_valid = 1'b1; clr_bits = '1;
      @(posedge clk); #1;
      clr_valid = 1'b0;
      chk(trap_sts == '0 && smi == 1'b0, "R8 R9 clear all",
          {trap_sts, 3'b0, smi}, 0);
    end
  endtask

  task automatic step(input logic v, input logic [AW-1:0] a, input logic wr,
                      input logic cv, input logic [NT-1:0] cb);
    @(negedge clk);
    hst_valid = v; hst_io = 1'b1; hst_write = wr; hst_addr = a;
    hst_wdata = ~a; clr_valid = cv; clr_bits = cb;
    @(posedge clk); #1;
    hst_valid = 1'b0; clr_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    hst_valid = 1'b0; hst_io = 1'b0; hst_write = 1'b0;
    hst_addr = '0; hst_wdata = '0; dev_rdata = '0;
    clr_valid = 1'b0; clr_bits = '0;
    base_a[0] = 8'h60; mask_a[0] = 8'h00;
    base_a[1] = 8'h60; mask_a[1] = 8'h0F;
    base_a[2] = 8'h80; mask_a[2] = 8'h3F;
    base_a[3] = 8'hF0; mask_a[3] = 8'h07;
    trap_arm = '0; trap_base = '0; trap_mask = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(trap_sts == '0 && smi == 1'b0, "R10 reset status", {trap_sts, 3'b0, smi}, 0);
    chk(cap_addr == '0 && cap_idx == '0 && cap_wdata == '0 && cap_write == 1'b0,
        "R10 reset capture", {cap_addr, cap_wdata}, 0);
    @(negedge clk); rst_n = 1'b1;

    // Sweeps under three arm patterns (R1..R9).
    for (int p = 0; p < 3; p++) begin
      load_cfg(p == 0 ? 4'b1111 : (p == 1 ? 4'b0110 : 4'b1001));
      for (int a = 0; a < 256; a++)
        for (int m = 0; m < 4; m++)
          sweep_one(AW'(a), m[0], m[1]);
    end

    // R7: capture holds while an earlier trap is pending.
    load_cfg(4'b0101);
    step(1'b1, 8'h60, 1'b1, 1'b0, '0);
    chk(trap_sts == 4'b0001 && cap_addr == 8'h60, "R7 first capture",
        {trap_sts, cap_addr}, {4'b0001, 8'h60});
    step(1'b1, 8'h85, 1'b0, 1'b0, '0);
    chk(trap_sts == 4'b0101, "R5 second set", 32'(trap_sts), 32'h5);
    chk(cap_addr == 8'h60 && cap_idx == 2'd0 && cap_write == 1'b1 &&
        cap_wdata == 8'h9F, "R7 hold", {cap_write, cap_idx, cap_addr}, {1'b1, 2'd0, 8'h60});
    // R8: partial clear.
    step(1'b0, 8'h00, 1'b0, 1'b1, 4'b0001);
    chk(trap_sts == 4'b0100 && smi == 1'b1, "R8 R9 partial clear",
        {trap_sts, 3'b0, smi}, {4'b0100, 4'b0001});
    // R8: set wins over clear of the same bit.
    step(1'b1, 8'h85, 1'b0, 1'b1, 4'b0100);
    chk(trap_sts == 4'b0100, "R8 set wins", 32'(trap_sts), 32'h4);
    step(1'b0, 8'h00, 1'b0, 1'b1, 4'b1111);
    chk(trap_sts == '0 && smi == 1'b0, "R8 R9 final clear", {trap_sts, 3'b0, smi}, 0);
    // R1: disarmed slot 1 window address is forwarded.
    @(negedge clk);
    hst_valid = 1'b1; hst_io = 1'b1; hst_write = 1'b0; hst_addr = 8'h62;
    dev_rdata = 8'h33;
    #1;
    chk(dev_valid == 1'b1 && hst_rdata == 8'h33, "R1 disarmed forward",
        {dev_valid, hst_rdata}, {1'b1, 8'h33});
    @(posedge clk); #1;
    hst_valid = 1'b0;
    chk(trap_sts == '0, "R1 disarmed no status", 32'(trap_sts), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule